// File: doc/BRIEF.md
# Serial Control Port Register File

This block is the digital front end of a stereo volume controller. A host reaches it over a three-wire serial link made of an active-low select, a serial clock and one data line. The data line is shared between reading and writing. Every transaction is sixteen clocks long and sent most significant bit first. The first byte names a register and the direction of transfer. The second byte carries the value.

All three link inputs are sampled into the system clock domain, and their edges are found there. Writes are committed when the select line returns high after exactly sixteen clocks. Reads send the chosen register back on the data line. The output driver is enabled only while the select line is low.

The block holds these 8-bit registers:
- left gain
- right gain
- peak reference code
- peak status
- test control

A write-only alias address loads both gains at once. The gain logic receives the register values and a one-cycle strobe per channel. The peak detectors report overload events, which set sticky status flags. Those flags clear when the status register has been read. The test register steers the direction and the signal selection of the mute pin.

Top module: `sctl_top`

## Requirements
- R1: A transaction is 16 rising serial-clock edges with select low, sampled MSB first: an address byte and then a data byte. In the address byte, bits 6..3 are the register code and bit 2 is the direction (1 read, 0 write). Bits 7, 1 and 0 have no effect. A write takes effect after the select line rises.
- R2: Register codes are: 1101 left gain, 1110 right gain, 1100 peak reference, 1011 peak status (read-only), 1111 test, and 1001 both gains (write-only).
- R3: After reset, both gains, the test register and the status flags are 0, and the peak reference is 0xFF.
- R4: On a read, the register value is driven on `sdo_o`, MSB first. Bit 7 is driven after the falling serial-clock edge that follows the 8th rising edge. Each later falling edge moves to the next lower bit, so each bit is valid before the rising edge that follows.
- R5: `sdo_oe_o` is low whenever select is high, during the address byte, and throughout write transactions. It is high during the data byte of a read.
- R6: A write to the both-gains code loads the same value into both gains and pulses both write strobes. A read of that code returns 0x00.
- R7: A transaction with any number of rising edges other than 16 before select rises changes no register and pulses no strobe.
- R8: An overload input sets its status flag one cycle later: bit 1 for left, bit 0 for right. The flag stays set while no status read completes.
- R9: A completed 16-clock read of the status register clears both flags when select rises. An overload input that is high in the clearing cycle keeps its flag set.
- R10: Test register bit 1 drives `test_out_en_o`, and test register bits 5..2 drive `test_sel_o`.
- R11: Each gain write pulses that channel's strobe for exactly one system clock, in the same cycle that the new value appears. A gain output never changes without its strobe.
- R12: Writes to unknown codes and to the status code change no register. Reads of unknown codes return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data from host (input side of shared pin) |
| sdo_o | output | 1 | Serial read data (output side of shared pin) |
| sdo_oe_o | output | 1 | Output enable for the shared data pin |
| ovld_left_i | input | 1 | Left peak detector overload event |
| ovld_right_i | input | 1 | Right peak detector overload event |
| gain_left_o | output | 8 | Left gain code |
| gain_right_o | output | 8 | Right gain code |
| gain_left_wr_o | output | 1 | One-cycle left gain update strobe |
| gain_right_wr_o | output | 1 | One-cycle right gain update strobe |
| peak_ref_o | output | 8 | Peak reference DAC code |
| test_out_en_o | output | 1 | Mute pin turns into an output |
| test_sel_o | output | 4 | Internal signal selection for the mute pin |

## Verification
The bench uses the default parameters: two synchroniser stages and 8-bit registers. With those, a frame is 16 clocks and the saturating bit counter is 5 bits wide. The serial clock runs at one sixteenth of the system clock rate, which leaves several idle cycles after each synchronised edge. Read bits can then be sampled just before each rising edge. Frames of 10 and 17 clocks reach the abort path from both sides of the valid length. Holding an overload input high across a status read reaches the case where an event and a clear meet in the same cycle.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    typedef enum logic [3:0] {
        CODE_BOTH   = 4'b1001,
        CODE_STATUS = 4'b1011,
        CODE_PKREF  = 4'b1100,
        CODE_GAIN_L = 4'b1101,
        CODE_GAIN_R = 4'b1110,
        CODE_TEST   = 4'b1111
    } reg_code_e;

    localparam int CODE_LSB = 3;
    localparam int RD_BIT   = 2;

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
        end else begin
            st_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
    import sctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          csn_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data_i,
    output logic [3:0]    rd_code_o,
    output logic          wr_stb_o,
    output logic          rd_done_o,
    output logic [3:0]    frm_code_o,
    output logic [DW-1:0] frm_data_o,
    output logic          sdo_o,
    output logic          sdo_oe_o
);
    localparam int FRAME = 2 * DW;
    localparam int CW    = $clog2(FRAME) + 1;
    localparam logic [CW-1:0] CNT_MAX  = '1;
    localparam logic [CW-1:0] CNT_FULL = CW'(FRAME);
    localparam logic [CW-1:0] CNT_HALF = CW'(DW);

    typedef struct packed {
        logic             p_sclk;
        logic             p_csn;
        logic [CW-1:0]    cnt;
        logic [FRAME-1:0] sr_in;
        logic [DW-1:0]    sr_out;
        logic             oe;
        logic             wr;
        logic             rd;
        logic [3:0]       code;
        logic [DW-1:0]    data;
    } frm_st_t;

    frm_st_t d, q;
    logic rise, fall, cs_rise;

    always_comb begin
        d       = q;
        rise    = sclk_s & ~q.p_sclk;
        fall    = ~sclk_s & q.p_sclk;
        cs_rise = csn_s & ~q.p_csn;
        d.p_sclk = sclk_s;
        d.p_csn  = csn_s;
        d.wr     = 1'b0;
        d.rd     = 1'b0;

        if (cs_rise && q.cnt == CNT_FULL) begin
            d.code = q.sr_in[DW + CODE_LSB +: 4];
            d.data = q.sr_in[DW-1:0];
            d.wr   = ~q.sr_in[DW + RD_BIT];
            d.rd   = q.sr_in[DW + RD_BIT];
        end

        if (csn_s) begin
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (rise) begin
            d.sr_in = {q.sr_in[FRAME-2:0], sdi_s};
            d.cnt   = (q.cnt == CNT_MAX) ? q.cnt : q.cnt + 1'b1;
        end else if (fall) begin
            if (q.cnt == CNT_HALF && q.sr_in[RD_BIT]) begin
                d.sr_out = rd_data_i;
                d.oe     = 1'b1;
            end else if (q.oe && q.cnt > CNT_HALF && q.cnt < CNT_FULL) begin
                d.sr_out = {q.sr_out[DW-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.p_csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_code_o  = q.sr_in[CODE_LSB +: 4];
    assign wr_stb_o   = q.wr;
    assign rd_done_o  = q.rd;
    assign frm_code_o = q.code;
    assign frm_data_o = q.data;
    assign sdo_o      = q.sr_out[DW-1];
    assign sdo_oe_o   = q.oe;

    // R5: driver released once select has been high for a cycle
    assert_oe_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |-> !q.oe);

    // R7: a commit only follows a high select
    assert_commit_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr || q.rd) |-> $past(csn_s));
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb_i,
    input  logic          rd_done_i,
    input  logic [3:0]    frm_code_i,
    input  logic [DW-1:0] frm_data_i,
    input  logic [3:0]    rd_code_i,
    input  logic          ovld_l_i,
    input  logic          ovld_r_i,
    output logic [DW-1:0] rd_data_o,
    output logic [DW-1:0] gain_l_o,
    output logic [DW-1:0] gain_r_o,
    output logic          gain_l_wr_o,
    output logic          gain_r_wr_o,
    output logic [DW-1:0] pkref_o,
    output logic [DW-1:0] test_o
);
    typedef struct packed {
        logic [DW-1:0] gl;
        logic [DW-1:0] gr;
        logic          lwr;
        logic          rwr;
        logic [DW-1:0] pkref;
        logic [DW-1:0] test;
        logic [1:0]    stat;
    } reg_st_t;

    reg_st_t d, q;
    logic clr;

    always_comb begin
        d     = q;
        d.lwr = 1'b0;
        d.rwr = 1'b0;
        if (wr_stb_i) begin
            case (frm_code_i)
                CODE_GAIN_L: begin d.gl = frm_data_i; d.lwr = 1'b1; end
                CODE_GAIN_R: begin d.gr = frm_data_i; d.rwr = 1'b1; end
                CODE_BOTH: begin
                    d.gl  = frm_data_i;
                    d.gr  = frm_data_i;
                    d.lwr = 1'b1;
                    d.rwr = 1'b1;
                end
                CODE_PKREF:  d.pkref = frm_data_i;
                CODE_TEST:   d.test  = frm_data_i;
                default: ;
            endcase
        end
        clr    = rd_done_i && (frm_code_i == CODE_STATUS);
        d.stat = (clr ? 2'b00 : q.stat) | {ovld_l_i, ovld_r_i};
    end

    always_comb begin
        case (rd_code_i)
            CODE_GAIN_L: rd_data_o = q.gl;
            CODE_GAIN_R: rd_data_o = q.gr;
            CODE_PKREF:  rd_data_o = q.pkref;
            CODE_TEST:   rd_data_o = q.test;
            CODE_STATUS: rd_data_o = {{(DW-2){1'b0}}, q.stat};
            default:     rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.pkref <= '1;
        end else begin
            q <= d;
        end
    end

    assign gain_l_o    = q.gl;
    assign gain_r_o    = q.gr;
    assign gain_l_wr_o = q.lwr;
    assign gain_r_wr_o = q.rwr;
    assign pkref_o     = q.pkref;
    assign test_o      = q.test;

    assert_flag_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovld_l_i |=> q.stat[1]);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stat[0] && !(rd_done_i && frm_code_i == CODE_STATUS)) |=> q.stat[0]);

    assert_gain_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.gl) |-> q.lwr);

    assert_alias_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lwr && q.rwr) |-> (q.gl == q.gr));
endmodule

// File: rtl/sctl_top.sv
module sctl_top #(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_i,
    input  logic          csn_i,
    input  logic          sdi_i,
    output logic          sdo_o,
    output logic          sdo_oe_o,
    input  logic          ovld_left_i,
    input  logic          ovld_right_i,
    output logic [DW-1:0] gain_left_o,
    output logic [DW-1:0] gain_right_o,
    output logic          gain_left_wr_o,
    output logic          gain_right_wr_o,
    output logic [DW-1:0] peak_ref_o,
    output logic          test_out_en_o,
    output logic [3:0]    test_sel_o
);
    logic [2:0]    pins_s;
    logic [DW-1:0] rd_data, frm_data, test_q;
    logic [3:0]    rd_code, frm_code;
    logic          wr_stb, rd_done;

    sctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, csn_i, sdi_i}),
        .q_o   (pins_s)
    );

    sctl_frame #(.DW(DW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[2]),
        .csn_s      (pins_s[1]),
        .sdi_s      (pins_s[0]),
        .rd_data_i  (rd_data),
        .rd_code_o  (rd_code),
        .wr_stb_o   (wr_stb),
        .rd_done_o  (rd_done),
        .frm_code_o (frm_code),
        .frm_data_o (frm_data),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o)
    );

    sctl_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb_i    (wr_stb),
        .rd_done_i   (rd_done),
        .frm_code_i  (frm_code),
        .frm_data_i  (frm_data),
        .rd_code_i   (rd_code),
        .ovld_l_i    (ovld_left_i),
        .ovld_r_i    (ovld_right_i),
        .rd_data_o   (rd_data),
        .gain_l_o    (gain_left_o),
        .gain_r_o    (gain_right_o),
        .gain_l_wr_o (gain_left_wr_o),
        .gain_r_wr_o (gain_right_wr_o),
        .pkref_o     (peak_ref_o),
        .test_o      (test_q)
    );

    assign test_out_en_o = test_q[1];
    assign test_sel_o    = test_q[5:2];

    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gain_left_wr_o |=> !gain_left_wr_o);
endmodule

// File: tb/tb_sctl_top.sv
module tb_sctl_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic ovl = 1'b0, ovr = 1'b0;
    logic sdo, sdo_oe, lwr, rwr, ten;
    logic [7:0] gl, gr, pref;
    logic [3:0] tsel;

    int checks = 0, fails = 0, nl = 0, nr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sctl_top dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ovld_left_i(ovl), .ovld_right_i(ovr),
        .gain_left_o(gl), .gain_right_o(gr), .gain_left_wr_o(lwr),
        .gain_right_wr_o(rwr), .peak_ref_o(pref), .test_out_en_o(ten),
        .test_sel_o(tsel)
    );

    always @(posedge clk) begin
        if (lwr) nl++;
        if (rwr) nr++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ab(input logic [3:0] code, input logic rd);
        return {1'b1, code, rd, 2'b11};
    endfunction

    // one framed transfer; rdata holds the bits seen before rising edges 9..16
    task automatic xfer(input logic [7:0] a, input logic [7:0] dat, input int nclk,
                        output logic [7:0] rdata, output bit oe_addr, output bit oe_data);
        logic [15:0] w;
        w = {a, dat};
        rdata = 8'h00; oe_addr = 0; oe_data = 1;
        tick(2); csn = 1'b0; tick(HALF);
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            tick(HALF);
            if (i >= 8 && i < 16) begin
                rdata[15-i] = sdo;
                if (!sdo_oe) oe_data = 0;
            end else if (sdo_oe) oe_addr = 1;
            sclk = 1'b1; tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF); csn = 1'b1; tick(12);
    endtask

    task automatic wr(input logic [3:0] code, input logic [7:0] v, output bit oe_any);
        logic [7:0] r; bit oa, od;
        xfer(ab(code, 1'b0), v, 16, r, oa, od);
        oe_any = oa | od;
    endtask

    task automatic rd(input logic [3:0] code, output logic [7:0] v, output bit oe_ok);
        bit oa, od;
        xfer(ab(code, 1'b1), 8'hFF, 16, v, oa, od);
        oe_ok = !oa && od;
    endtask

    task automatic t_reset;
        logic [7:0] v; bit ok;
        check(gl == 8'h00 && gr == 8'h00, "R3 gains", {gl, gr}, 0);
        check(pref == 8'hFF, "R3 peak ref", pref, 8'hFF);
        check(!ten && tsel == 4'h0, "R3 test", {ten, tsel}, 0);
        check(!sdo_oe, "R5 idle", sdo_oe, 0);
        rd(4'b1011, v, ok);
        check(v == 8'h00, "R3 status", v, 0);
        rd(4'b1100, v, ok);
        check(v == 8'hFF, "R3 peak ref read", v, 8'hFF);
    endtask

    task automatic t_write_gains;
        bit oe; int l0, r0;
        l0 = nl; r0 = nr;
        wr(4'b1101, 8'h5A, oe);
        check(!oe, "R5 write no drive", oe, 0);
        wr(4'b1110, 8'hC3, oe);
        check(gl == 8'h5A, "R2 left gain", gl, 8'h5A);
        check(gr == 8'hC3, "R2 right gain", gr, 8'hC3);
        check(nl - l0 == 1 && nr - r0 == 1, "R11 one strobe each", (nl - l0) * 16 + (nr - r0), 8'h11);
    endtask

    task automatic t_readback;
        logic [7:0] v; bit ok;
        rd(4'b1101, v, ok);
        check(v == 8'h5A, "R4 read left", v, 8'h5A);
        check(ok, "R5 drive only in data byte", ok, 1);
        rd(4'b1110, v, ok);
        check(v == 8'hC3, "R4 read right", v, 8'hC3);
        check(gl == 8'h5A, "R12 read leaves gain", gl, 8'h5A);
    endtask

    task automatic t_dontcare;
        logic [7:0] r; bit oa, od;
        xfer({1'b0, 4'b1100, 1'b0, 2'b00}, 8'h3C, 16, r, oa, od);
        check(pref == 8'h3C, "R1 dont-care bits", pref, 8'h3C);
    endtask

    task automatic t_alias;
        logic [7:0] v; bit oe; int l0, r0;
        l0 = nl; r0 = nr;
        wr(4'b1001, 8'h77, oe);
        check(gl == 8'h77 && gr == 8'h77, "R6 both gains", {gl, gr}, 16'h7777);
        check(nl - l0 == 1 && nr - r0 == 1, "R6 both strobes", (nl - l0) * 16 + (nr - r0), 8'h11);
        rd(4'b1001, v, oe);
        check(v == 8'h00, "R6 alias read zero", v, 0);
    endtask

    task automatic t_abort;
        logic [7:0] r; bit oa, od; int l0;
        l0 = nl;
        xfer(ab(4'b1101, 1'b0), 8'h11, 10, r, oa, od);
        check(gl == 8'h77, "R7 short frame", gl, 8'h77);
        xfer(ab(4'b1101, 1'b0), 8'h11, 17, r, oa, od);
        check(gl == 8'h77, "R7 long frame", gl, 8'h77);
        check(nl == l0, "R7 no strobe", nl - l0, 0);
    endtask

    task automatic t_status;
        logic [7:0] v; bit ok;
        tick(1); ovl = 1'b1; tick(1); ovl = 1'b0; tick(4);
        rd(4'b1011, v, ok);
        check(v == 8'h02, "R8 left flag", v, 2);
        rd(4'b1011, v, ok);
        check(v == 8'h00, "R9 cleared on read", v, 0);
        ovr = 1'b1; tick(1); ovr = 1'b0; tick(300);
        rd(4'b1011, v, ok);
        check(v == 8'h01, "R8 right flag held", v, 1);
        ovl = 1'b1;
        rd(4'b1011, v, ok);
        rd(4'b1011, v, ok);
        check(v == 8'h02, "R9 event beats clear", v, 2);
        ovl = 1'b0;
        rd(4'b1011, v, ok);
        check(v == 8'h02, "R9 still set after drop", v, 2);
        rd(4'b1011, v, ok);
        check(v == 8'h00, "R9 clear after drop", v, 0);
    endtask

    task automatic t_test;
        logic [7:0] v; bit oe;
        wr(4'b1111, 8'h16, oe);
        check(ten && tsel == 4'h5, "R10 test 0x16", {ten, tsel}, 5'h15);
        rd(4'b1111, v, oe);
        check(v == 8'h16, "R10 test readback", v, 8'h16);
        wr(4'b1111, 8'h20, oe);
        check(!ten && tsel == 4'h8, "R10 test 0x20", {ten, tsel}, 5'h08);
    endtask

    task automatic t_unknown;
        logic [7:0] v; bit oe;
        wr(4'b0000, 8'hAA, oe);
        check(gl == 8'h77 && gr == 8'h77 && pref == 8'h3C, "R12 unknown write", {gl, gr, pref}, 24'h77773C);
        rd(4'b0000, v, oe);
        check(v == 8'h00, "R12 unknown read", v, 0);
        wr(4'b1011, 8'h03, oe);
        rd(4'b1011, v, oe);
        check(v == 8'h00, "R12 status read-only", v, 0);
    endtask

    initial begin
        tick(5); rst_n = 1'b1; tick(5);
        t_reset;
        t_write_gains;
        t_readback;
        t_dontcare;
        t_alias;
        t_abort;
        t_status;
        t_test;
        t_unknown;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule